// File: doc/BRIEF.md
# Serial BER Pattern Transmitter

This block produces the outgoing serial test stream of a bit error rate tester. After a start pulse it sends frames back to back until a stop pulse: each frame opens with a run of synchronization bytes and continues with a payload taken from an on-chip pattern memory. Host logic fills the memory beforehand through a simple write port. Because every frame carries its own sync run, a receiver can regain alignment many times during one test.

Bits leave on `ser_data` with a companion clock `ser_clk`. A programmable divider of the system clock sets the bit period. For example, a divider setting of 49 on an 80 MHz clock gives 1.6 Mb/s. Sync bytes are framed with a trailing stop bit so that the receiver can confirm byte alignment. Payload bytes are sent without framing. On request, the block inverts exactly one payload bit at a pseudo-random position and reports that position so the far end's error count can be verified.

Configuration inputs are read live and must be held stable while the block is busy.

Top module: `ber_pattern_tx`

## Requirements
- R1: Out of reset the block is idle: `ser_data` = 1, `ser_clk` = 1, `busy` = 0, `err_pos_vld` = 0.
- R2: A frame begins with `cfg_sync_len` copies of `cfg_sync_byte`. Each copy is sent MSB first and is followed by one stop bit of value 1, so each sync byte occupies 9 bit slots.
- R3: Right after the sync run, the frame carries `cfg_pay_last`+1 payload bytes read from pattern memory addresses 0 upward. Each byte is sent MSB first with no stop bit. The memory contents are set through `mem_we`/`mem_addr`/`mem_wdata`.
- R4: After a start pulse in idle, `busy` is 1 and frames repeat back to back with no gap until a stop pulse.
- R5: Each bit slot lasts `cfg_div`+1 system clocks, with `cfg_div` ≥ 1. `ser_clk` falls in the cycle `ser_data` changes and rises mid-slot, so successive `ser_clk` rising edges are `cfg_div`+1 clocks apart.
- R6: With `cfg_sync_len` = 0, frames consist of payload only, sent back to back.
- R7: An error request makes exactly one payload bit of one frame inverted. Its index is byte×8 + bit offset from the MSB, and it is below the payload size in bits. The index is shown on `err_pos` together with a one-cycle `err_pos_vld` pulse as that payload begins.
- R8: An error request is held pending and applies only to the next payload to begin; later payloads are sent unaltered. A request made while a payload is being sent applies to the following frame's payload.
- R9: A stop pulse returns the block to idle: `busy` = 0, and within two cycles `ser_data` = 1 and `ser_clk` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Bit period minus one, in system clocks (≥ 1) |
| cfg_sync_len | input | SLEN_W | Number of sync bytes per frame (0 = none) |
| cfg_sync_byte | input | 8 | Value of each sync byte |
| cfg_pay_last | input | AW | Payload length in bytes minus one |
| mem_we | input | 1 | Pattern memory write strobe |
| mem_addr | input | AW | Pattern memory write address |
| mem_wdata | input | 8 | Pattern memory write byte |
| start | input | 1 | Start pulse, taken in idle |
| stop | input | 1 | Stop pulse, taken while busy |
| err_req | input | 1 | Request one bit flip in the next payload |
| ser_data | output | 1 | Serial data out |
| ser_clk | output | 1 | Bit clock out, rising mid-slot |
| busy | output | 1 | Frames being sent |
| err_pos_vld | output | 1 | One-cycle strobe for `err_pos` |
| err_pos | output | AW+3 | Bit index of the inverted payload bit |

## Verification
The bench compares every bit at each `ser_clk` rise against a queue of expected bits built from the configuration. A block that dropped the stop bit, sent LSB first or let a frame boundary slip would shift the whole stream and fail at once. It covers runs with no sync bytes, where a design that still emitted an empty sync phase would insert stray bits. It also times every slot, which catches an off-by-one in the divider. Error runs check that exactly one payload bit differs, at the reported index and in the right frame. The request is placed both before start and in the middle of a payload, so a design that flipped the current payload, flipped every frame or lost the pending request would be caught.

// File: rtl/ber_tx_pkg.sv
package ber_tx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_PAY  = 2'd2
  } phase_t;

  localparam int unsigned SYNC_SLOTS = 9;  // 8 data bits plus stop bit
  localparam logic [15:0] LFSR_SEED  = 16'hACE1;

endpackage

// File: rtl/ber_baud_gen.sv
module ber_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             ser_clk
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             half;

  assign tick = run && (cnt_q == div);
  assign half = run && (cnt_q == (div >> 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_comb begin
    if (!run)      sclk_d = 1'b1;
    else if (tick) sclk_d = 1'b0;
    else if (half) sclk_d = 1'b1;
    else           sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign ser_clk = sclk_q;

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));

  assert_clk_low_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !ser_clk);

endmodule

// File: rtl/ber_pat_mem.sv
module ber_pat_mem #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/ber_err_inject.sv
module ber_err_inject #(
  parameter int unsigned PBW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           enter_pay,
  input  logic [PBW:0]   pay_bits,
  output logic           armed,
  output logic [PBW-1:0] pos,
  output logic           pos_vld
);

  import ber_tx_pkg::*;

  logic [15:0]    lfsr_q, lfsr_d;
  logic           pend_q, pend_d;
  logic           armed_q, armed_d;
  logic [PBW-1:0] pos_q, pos_d;
  logic           vld_q, vld_d;
  logic [15:0]    bits16;
  logic           want;

  assign bits16 = 16'(pay_bits);
  assign want   = pend_q | req;

  always_comb begin
    lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_comb begin
    pend_d  = want;
    armed_d = armed_q;
    pos_d   = pos_q;
    vld_d   = 1'b0;
    if (enter_pay) begin
      pend_d  = 1'b0;
      armed_d = want;
      vld_d   = want;
      if (want) pos_d = PBW'(lfsr_q % bits16);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= LFSR_SEED;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      pos_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      lfsr_q  <= lfsr_d;
      pend_q  <= pend_d;
      armed_q <= armed_d;
      pos_q   <= pos_d;
      vld_q   <= vld_d;
    end
  end

  assign armed   = armed_q;
  assign pos     = pos_q;
  assign pos_vld = vld_q;

  assert_pos_in_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_vld |-> ({1'b0, pos} < pay_bits));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_vld |=> !pos_vld);

  assert_request_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pos_vld |-> !pend_q);

endmodule

// File: rtl/ber_pattern_tx.sv
module ber_pattern_tx #(
  parameter int unsigned AW     = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [SLEN_W-1:0] cfg_sync_len,
  input  logic [7:0]        cfg_sync_byte,
  input  logic [AW-1:0]     cfg_pay_last,
  input  logic              mem_we,
  input  logic [AW-1:0]     mem_addr,
  input  logic [7:0]        mem_wdata,
  input  logic              start,
  input  logic              stop,
  input  logic              err_req,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              busy,
  output logic              err_pos_vld,
  output logic [AW+2:0]     err_pos
);

  import ber_tx_pkg::*;

  localparam int unsigned PBW = AW + 3;
  localparam int unsigned CW  = (AW > SLEN_W) ? AW : SLEN_W;

  phase_t          phase_q, phase_d;
  logic [CW-1:0]   byte_q, byte_d;
  logic [3:0]      bit_q, bit_d;
  logic            data_q, data_d;
  logic            enter_pay;
  logic            tick;
  logic [7:0]      rd_byte;
  logic            armed;
  logic [PBW:0]    pay_bits;
  logic [PBW-1:0]  flat_idx;
  logic            sync_bit, pay_bit;
  logic            last_sync, last_pay;

  ber_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (phase_q != PH_IDLE),
    .div     (cfg_div),
    .tick    (tick),
    .ser_clk (ser_clk)
  );

  ber_pat_mem #(.AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (byte_q[AW-1:0]),
    .rdata (rd_byte)
  );

  assign pay_bits = {({1'b0, cfg_pay_last} + (AW+1)'(1)), 3'b000};

  ber_err_inject #(.PBW(PBW)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (err_req),
    .enter_pay (enter_pay),
    .pay_bits  (pay_bits),
    .armed     (armed),
    .pos       (err_pos),
    .pos_vld   (err_pos_vld)
  );

  assign flat_idx  = {byte_q[AW-1:0], bit_q[2:0]};
  assign sync_bit  = (bit_q == 4'd8) ? 1'b1 : cfg_sync_byte[3'd7 - bit_q[2:0]];
  assign pay_bit   = rd_byte[3'd7 - bit_q[2:0]] ^ (armed && (flat_idx == err_pos));
  assign last_sync = (byte_q == CW'(cfg_sync_len) - CW'(1));
  assign last_pay  = (byte_q[AW-1:0] == cfg_pay_last);

  always_comb begin
    phase_d   = phase_q;
    byte_d    = byte_q;
    bit_d     = bit_q;
    data_d    = data_q;
    enter_pay = 1'b0;
    if (phase_q == PH_IDLE) begin
      data_d = 1'b1;
      if (start) begin
        byte_d = '0;
        bit_d  = '0;
        if (cfg_sync_len != '0) begin
          phase_d = PH_SYNC;
        end else begin
          phase_d   = PH_PAY;
          enter_pay = 1'b1;
        end
      end
    end else if (stop) begin
      phase_d = PH_IDLE;
      data_d  = 1'b1;
    end else if (tick) begin
      if (phase_q == PH_SYNC) begin
        data_d = sync_bit;
        if (bit_q == 4'(SYNC_SLOTS - 1)) begin
          bit_d = '0;
          if (last_sync) begin
            byte_d    = '0;
            phase_d   = PH_PAY;
            enter_pay = 1'b1;
          end else begin
            byte_d = byte_q + CW'(1);
          end
        end else begin
          bit_d = bit_q + 4'd1;
        end
      end else begin
        data_d = pay_bit;
        if (bit_q == 4'd7) begin
          bit_d = '0;
          if (last_pay) begin
            byte_d = '0;
            if (cfg_sync_len == '0) enter_pay = 1'b1;
            else                    phase_d   = PH_SYNC;
          end else begin
            byte_d = byte_q + CW'(1);
          end
        end else begin
          bit_d = bit_q + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      byte_q  <= '0;
      bit_q   <= '0;
      data_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
      data_q  <= data_d;
    end
  end

  assign ser_data = data_q;
  assign busy     = (phase_q != PH_IDLE);

  assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && $past(phase_q) == PH_IDLE) |-> (ser_data && ser_clk));

  assert_sync_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SYNC) |-> (byte_q < CW'(cfg_sync_len)));

  assert_stop_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && phase_q == PH_SYNC && bit_q == 4'd8) |=> ser_data);

  assert_pay_bit_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAY) |-> (bit_q < 4'd8));

  assert_start_leaves_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start) |=> busy);

endmodule

// File: tb/ber_pattern_tx_tb.sv
module ber_pattern_tx_tb;

  localparam int AW = 8;

  typedef struct {
    bit b;
    int frame;
    int pidx;
  } exp_bit_t;

  logic        clk, rst_n;
  logic [15:0] cfg_div;
  logic [7:0]  cfg_sync_len, cfg_sync_byte;
  logic [7:0]  cfg_pay_last;
  logic        mem_we;
  logic [7:0]  mem_addr, mem_wdata;
  logic        start, stop, err_req;
  logic        ser_data, ser_clk, busy, err_pos_vld;
  logic [10:0] err_pos;

  int tests, fails;
  exp_bit_t exp_q[$];
  bit [7:0] pat [256];

  bit mon_en, have_prev, prev_sclk;
  int cyc, last_rise, exp_period, popped;
  int flip_cnt, flip_frame, flip_idx;
  int vld_cnt, cap_pos;
  bit done;

  ber_pattern_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_sync_len(cfg_sync_len),
    .cfg_sync_byte(cfg_sync_byte), .cfg_pay_last(cfg_pay_last),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .start(start), .stop(stop), .err_req(err_req),
    .ser_data(ser_data), .ser_clk(ser_clk), .busy(busy),
    .err_pos_vld(err_pos_vld), .err_pos(err_pos)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pop one expected bit per ser_clk rise, check timing
  always @(negedge clk) begin
    cyc++;
    if (err_pos_vld) begin
      vld_cnt++;
      cap_pos = int'(err_pos);
    end
    if (mon_en && ser_clk && !prev_sclk) begin
      if (have_prev) chk(cyc - last_rise == exp_period, "R5", "bit period",
                         cyc - last_rise, exp_period);
      have_prev = 1'b1;
      last_rise = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected extra bit", 1, 0);
      end else begin
        exp_bit_t e;
        e = exp_q.pop_front();
        popped++;
        if (e.pidx >= 0 && ser_data != e.b) begin
          flip_cnt++;
          flip_frame = e.frame;
          flip_idx   = e.pidx;
        end else begin
          chk(ser_data == e.b, (e.pidx < 0) ? "R2" : "R3", "serial bit",
              int'(ser_data), int'(e.b));
        end
      end
    end
    prev_sclk = ser_clk;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk) err_req = 1'b1;
    @(negedge clk) err_req = 1'b0;
  endtask

  task automatic load_pattern();
    for (int i = 0; i < 256; i++) begin
      pat[i] = 8'((i * 37 + 11) ^ (i >> 2));
      @(negedge clk);
      mem_we = 1'b1; mem_addr = 8'(i); mem_wdata = pat[i];
    end
    @(negedge clk) mem_we = 1'b0;
  endtask

  // driver: queue the expected stream for a number of frames
  task automatic push_frames(input int frames, input int slen, input int sbyte,
                             input int pbytes);
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < slen; s++) begin
        for (int k = 7; k >= 0; k--) exp_q.push_back('{b: sbyte[k], frame: f, pidx: -1});
        exp_q.push_back('{b: 1'b1, frame: f, pidx: -1});
      end
      for (int p = 0; p < pbytes; p++)
        for (int k = 7; k >= 0; k--)
          exp_q.push_back('{b: pat[p][k], frame: f, pidx: p * 8 + (7 - k)});
    end
  endtask

  // err_mode 0: none, 1: request before start, 2: request inside frame 0 payload
  task automatic run(input int div, input int slen, input int sbyte, input int plast,
                     input int frames, input int err_mode, input int exp_frame);
    cfg_div = 16'(div); cfg_sync_len = 8'(slen); cfg_sync_byte = 8'(sbyte);
    cfg_pay_last = 8'(plast);
    exp_q.delete();
    push_frames(frames, slen, sbyte, plast + 1);
    flip_cnt = 0; vld_cnt = 0; popped = 0; have_prev = 1'b0;
    exp_period = div + 1;
    mon_en = 1'b1;
    if (err_mode == 1) pulse_err();
    pulse_start();
    @(negedge clk);
    chk(busy == 1'b1, "R4", "busy while running", int'(busy), 1);
    if (err_mode == 2) begin
      wait (popped >= slen * 9 + 5);
      pulse_err();
    end
    wait (exp_q.size() == 0);
    mon_en = 1'b0;
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after stop", int'(busy), 0);
    chk(ser_data == 1'b1, "R9", "data idle after stop", int'(ser_data), 1);
    chk(ser_clk == 1'b1, "R9", "clock idle after stop", int'(ser_clk), 1);
    prev_sclk = 1'b1;
    if (err_mode == 0) begin
      chk(flip_cnt == 0, "R3", "payload bits differing", flip_cnt, 0);
      chk(vld_cnt == 0, "R8", "error strobes", vld_cnt, 0);
    end else begin
      chk(flip_cnt == 1, "R7", "payload bits inverted", flip_cnt, 1);
      chk(vld_cnt == 1, "R7", "error strobes", vld_cnt, 1);
      chk(flip_idx == cap_pos, "R7", "inverted index vs err_pos", flip_idx, cap_pos);
      chk(cap_pos < (plast + 1) * 8, "R7", "err_pos inside payload", cap_pos, (plast + 1) * 8);
      chk(flip_frame == exp_frame, "R8", "frame holding the flip", flip_frame, exp_frame);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0; done = 1'b0; cyc = 0; last_rise = 0;
    mon_en = 1'b0; prev_sclk = 1'b1;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; err_req = 1'b0;
    mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    cfg_div = 16'd3; cfg_sync_len = 8'd2; cfg_sync_byte = 8'hA5; cfg_pay_last = 8'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_data == 1'b1, "R1", "reset ser_data", int'(ser_data), 1);
    chk(ser_clk == 1'b1, "R1", "reset ser_clk", int'(ser_clk), 1);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(err_pos_vld == 1'b0, "R1", "reset err_pos_vld", int'(err_pos_vld), 0);

    load_pattern();

    // R2 R3 R4 R5: two sync bytes, four payload bytes, three frames
    run(3, 2, 8'hA5, 3, 3, 0, 0);
    // R2 R3 R5: fastest divider, other sync byte, longer payload
    run(1, 1, 8'h3C, 9, 2, 0, 0);
    // R6: no sync run at all
    run(2, 0, 8'hFF, 5, 3, 0, 0);
    // R7 R8: request before start flips frame 0 only
    run(1, 2, 8'hC3, 15, 3, 1, 0);
    // R8: request inside frame 0 payload flips frame 1 only
    run(2, 1, 8'h5A, 7, 3, 2, 1);
    // R6 R7: error with payload-only frames
    run(1, 0, 8'h00, 2, 2, 1, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule